// File: doc/BRIEF.md
# Dual Circular Bit Tape

A peripheral for a one-bit controller that holds two independent strips of single-bit cells. Each strip has one active cell that the controller can read or toggle, and a pointer that steps one cell at a time towards either end. The controller talks to the strips through numbered I/O ports. On each port it can raise an output pulse carrying the value of its one-bit register, and it can sample a one-bit input line. Each strip owns three consecutive port numbers: step-left, data and step-right.

A write never stores a value. A high pulse on the data port inverts the active cell, so a program that wants a given value first XORs it against the current contents. Moving the pointer is slow on purpose: after every accepted step, the strip stays busy for a fixed number of cycles. During that time, reads of its data port return 0, and any high pulse aimed at that strip is dropped and reported on a one-cycle flag. The strips have a parameterised length, and the pointer wraps around at both ends. One strip usually holds program data and the other holds branch state.

Top module: `tape_pair`

## Requirements
- R1: After reset every cell of both strips is 0, each active pointer is at cell 0, and `busy` and `drop` are all 0.
- R2: `port_sel` carries a port number in binary. Strip t (t = 0, 1) uses port 3+3t for step-left, port 4+3t for data and port 5+3t for step-right. Any other number, including 0, 1 and 2, reads 0 and changes nothing in either strip.
- R3: A pulse (`port_stb`=1) with `port_val`=1 on a strip's step-left port, accepted while that strip is idle, makes cell (p+1) mod LEN the active cell.
- R4: A pulse with `port_val`=1 on a strip's step-right port, accepted while that strip is idle, makes cell (p+LEN-1) mod LEN the active cell, so cell 0 steps to cell LEN-1.
- R5: While `port_sel` names an idle strip's data port, `port_rd` equals that strip's active cell. Step ports always read 0.
- R6: A pulse with `port_val`=1 on an idle strip's data port inverts the active cell only. With `port_val`=0 the cell keeps its value.
- R7: An accepted step raises that strip's `busy` in the cycle after the edge and holds it for exactly SETTLE cycles.
- R8: While a strip is busy, a pulse with `port_val`=1 on any of its three ports changes neither its cells nor its pointer, and the strip's `drop` is 1 for the one cycle after that edge. A pulse with `port_val`=0 is not flagged.
- R9: While a strip is busy, reading its data port returns 0.
- R10: A command for one strip leaves the other strip's cells, pointer, `busy` and `drop` untouched.
- R11: With `port_stb`=0 nothing changes, whatever `port_sel` and `port_val` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_sel | input | PSEL_W | Addressed port number |
| port_stb | input | 1 | Output pulse strobe for the addressed port |
| port_val | input | 1 | Value carried by the output pulse |
| port_rd | output | 1 | Input line of the addressed port |
| busy | output | NTAPE | Per strip: step still settling |
| drop | output | NTAPE | Per strip: a high pulse was ignored in the previous cycle |

## Verification
A pointer that is off by one or wraps at the wrong end appears at `port_rd` the first time a previously toggled cell is read back after the next settle window. A toggle that lands in the wrong cell or the wrong strip appears at the first read of the cell that was meant to change. A settle counter of the wrong length shows on `busy` in the cycle where the window should open or close. A gating fault shows as a nonzero `port_rd` or a missing `drop` pulse within one cycle of a command issued while busy.

// File: rtl/tape_pkg.sv
package tape_pkg;

    typedef struct packed {
        logic go_left;
        logic go_right;
        logic flip;
    } tape_cmd_t;

    localparam int PORTS_PER_TAPE  = 3;
    localparam int FIRST_TAPE_PORT = 3;

    function automatic int left_port(input int t);
        return FIRST_TAPE_PORT + PORTS_PER_TAPE * t;
    endfunction

    function automatic int data_port(input int t);
        return left_port(t) + 1;
    endfunction

    function automatic int right_port(input int t);
        return left_port(t) + 2;
    endfunction

endpackage

// File: rtl/tape_port_dec.sv
module tape_port_dec
    import tape_pkg::*;
#(
    parameter int NTAPE  = 2,
    parameter int PSEL_W = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [PSEL_W-1:0]      port_sel_i,
    input  logic                   stb_i,
    input  logic                   val_i,
    output tape_cmd_t [NTAPE-1:0]  cmd_o,
    output logic [NTAPE-1:0]       data_sel_o
);

    logic                   pulse_hi;
    logic [3*NTAPE-1:0]     cmd_flat;

    assign pulse_hi = stb_i & val_i;

    for (genvar t = 0; t < NTAPE; t++) begin : g_dec
        localparam logic [PSEL_W-1:0] LP = PSEL_W'(left_port(t));
        localparam logic [PSEL_W-1:0] DP = PSEL_W'(data_port(t));
        localparam logic [PSEL_W-1:0] RP = PSEL_W'(right_port(t));

        always_comb begin
            cmd_o[t].go_left  = pulse_hi & (port_sel_i == LP);
            cmd_o[t].flip     = pulse_hi & (port_sel_i == DP);
            cmd_o[t].go_right = pulse_hi & (port_sel_i == RP);
            data_sel_o[t]     = (port_sel_i == DP);
        end

        assign cmd_flat[3*t +: 3] = cmd_o[t];
    end

    // R2: one port address can reach at most one command line
    a_r2_single_command: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(cmd_flat));

    // R11: without a strobe no command is issued
    a_r11_no_strobe_no_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stb_i |-> (cmd_flat == '0));

endmodule

// File: rtl/tape_settle.sv
module tape_settle #(
    parameter int SETTLE = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o
);

    localparam int CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else if (start_i) begin
            cnt_d = CNT_LOAD;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

    // R7: the owner never starts a new window while one is open
    a_r7_start_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> !busy_o);

    // R7: a window only counts down, it is never extended
    a_r7_window_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(busy_o) && busy_o) |-> (cnt_q < $past(cnt_q)));

    // R7: a window opens only after a start request
    a_r7_open_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i));

endmodule

// File: rtl/tape_core.sv
module tape_core
    import tape_pkg::*;
#(
    parameter int LEN    = 16,
    parameter int SETTLE = 4
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  tape_cmd_t cmd_i,
    output logic      rd_o,
    output logic      busy_o,
    output logic      drop_o
);

    localparam int PTR_W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(LEN - 1);

    typedef struct packed {
        logic [LEN-1:0]   cells;
        logic [PTR_W-1:0] ptr;
        logic             drop;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        busy;
    logic        any_cmd;
    logic        start_shift;

    tape_settle #(
        .SETTLE (SETTLE)
    ) u_settle (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_shift),
        .busy_o  (busy)
    );

    always_comb begin
        st_d        = st_q;
        any_cmd     = cmd_i.go_left | cmd_i.go_right | cmd_i.flip;
        start_shift = !busy & (cmd_i.go_left | cmd_i.go_right);
        st_d.drop   = busy & any_cmd;
        if (!busy) begin
            if (cmd_i.flip) begin
                st_d.cells[st_q.ptr] = ~st_q.cells[st_q.ptr];
            end
            if (cmd_i.go_left) begin
                st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
            end else if (cmd_i.go_right) begin
                st_d.ptr = (st_q.ptr == '0) ? LAST : st_q.ptr - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_o   = st_q.cells[st_q.ptr] & ~busy;
    assign busy_o = busy;
    assign drop_o = st_q.drop;

    // R7: every pointer move is followed by an open settle window
    a_r7_move_opens_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ptr != $past(st_q.ptr)) |-> busy);

    // R8: the pointer is frozen across a busy edge
    a_r8_ptr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(busy) |-> $stable(st_q.ptr));

    // R8: the cells are frozen across a busy edge
    a_r8_cells_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(busy) |-> $stable(st_q.cells));

    // R8: a drop flag always follows a busy cycle
    a_r8_drop_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drop_o |-> $past(busy));

    // R6: at most one cell changes per cycle
    a_r6_single_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(st_q.cells ^ $past(st_q.cells)) <= 1);

    // R9: the data line stays low while settling
    a_r9_quiet_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy |-> !rd_o);

endmodule

// File: rtl/tape_pair.sv
module tape_pair
    import tape_pkg::*;
#(
    parameter int NTAPE  = 2,
    parameter int LEN    = 16,
    parameter int SETTLE = 4,
    parameter int PSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PSEL_W-1:0] port_sel,
    input  logic              port_stb,
    input  logic              port_val,
    output logic              port_rd,
    output logic [NTAPE-1:0]  busy,
    output logic [NTAPE-1:0]  drop
);

    tape_cmd_t [NTAPE-1:0] cmd;
    logic [NTAPE-1:0]      data_sel;
    logic [NTAPE-1:0]      tape_rd;

    tape_port_dec #(
        .NTAPE  (NTAPE),
        .PSEL_W (PSEL_W)
    ) u_dec (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .port_sel_i (port_sel),
        .stb_i      (port_stb),
        .val_i      (port_val),
        .cmd_o      (cmd),
        .data_sel_o (data_sel)
    );

    for (genvar t = 0; t < NTAPE; t++) begin : g_tape
        tape_core #(
            .LEN    (LEN),
            .SETTLE (SETTLE)
        ) u_core (
            .clk_i  (clk),
            .rst_ni (rst_n),
            .cmd_i  (cmd[t]),
            .rd_o   (tape_rd[t]),
            .busy_o (busy[t]),
            .drop_o (drop[t])
        );
    end

    always_comb begin
        port_rd = 1'b0;
        for (int t = 0; t < NTAPE; t++) begin
            port_rd = port_rd | (data_sel[t] & tape_rd[t]);
        end
    end

    // R10: a drop on one strip never coincides with a command-free other strip
    // being disturbed; the strips raise drop only for their own busy windows
    a_r10_drop_needs_own_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ((drop & ~$past(busy)) == '0));

endmodule

// File: tb/tape_pair_test.sv
module tape_pair_test;

    localparam int NT     = 2;
    localparam int LEN    = 16;
    localparam int SETTLE = 4;
    localparam int PW     = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] sel = '0;
    logic          stb = 1'b0;
    logic          val = 1'b0;
    logic          rd;
    logic [NT-1:0] busy;
    logic [NT-1:0] drop;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    bit m_cells [NT][LEN];
    int m_ptr   [NT];
    int m_cnt   [NT];
    bit m_drop  [NT];

    tape_pair #(
        .NTAPE  (NT),
        .LEN    (LEN),
        .SETTLE (SETTLE),
        .PSEL_W (PW)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_sel (sel),
        .port_stb (stb),
        .port_val (val),
        .port_rd  (rd),
        .busy     (busy),
        .drop     (drop)
    );

    always #5 clk = ~clk;

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_rd(int s);
        for (int t = 0; t < NT; t++) begin
            if (s == 4 + 3 * t) return (m_cnt[t] == 0) ? int'(m_cells[t][m_ptr[t]]) : 0;
        end
        return 0;
    endfunction

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            for (int c = 0; c < LEN; c++) m_cells[t][c] = 1'b0;
            m_ptr[t]  = 0;
            m_cnt[t]  = 0;
            m_drop[t] = 1'b0;
        end
    endtask

    task automatic model_edge(int s, bit b, bit v);
        for (int t = 0; t < NT; t++) begin
            int base = 3 + 3 * t;
            bit bsy  = (m_cnt[t] != 0);
            bit hit  = b && v && (s >= base) && (s <= base + 2);
            m_drop[t] = bsy && hit;
            if (bsy) begin
                m_cnt[t]--;
            end else if (hit) begin
                if (s == base + 1) begin
                    m_cells[t][m_ptr[t]] = !m_cells[t][m_ptr[t]];
                end else if (s == base) begin
                    m_ptr[t] = (m_ptr[t] + 1) % LEN;
                    m_cnt[t] = SETTLE;
                end else begin
                    m_ptr[t] = (m_ptr[t] + LEN - 1) % LEN;
                    m_cnt[t] = SETTLE;
                end
            end
        end
    endtask

    // called just after a falling edge
    task automatic step(int s, bit b, bit v, string tag);
        sel = PW'(s);
        stb = b;
        val = v;
        @(posedge clk);
        model_edge(s, b, v);
        @(negedge clk);
        check(tag, "port_rd", int'(rd), exp_rd(s));
        for (int t = 0; t < NT; t++) begin
            check(tag, $sformatf("busy[%0d]", t), int'(busy[t]), int'(m_cnt[t] != 0));
            check(tag, $sformatf("drop[%0d]", t), int'(drop[t]), int'(m_drop[t]));
        end
    endtask

    task automatic idle(int s, int n, string tag);
        for (int i = 0; i < n; i++) step(s, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "busy", int'(busy), 0);
        check("R1", "drop", int'(drop), 0);
        step(4, 1'b0, 1'b0, "R1");
        step(7, 1'b0, 1'b0, "R1");
        // R6: toggle and low pulse
        step(4, 1'b1, 1'b1, "R6");
        step(4, 1'b1, 1'b0, "R6");
        // R11: strobe low
        step(4, 1'b0, 1'b1, "R11");
        step(3, 1'b0, 1'b1, "R11");
        // R10: other strip unaffected
        step(7, 1'b0, 1'b0, "R10");
        // R5: step ports read 0 even with a set cell
        step(3, 1'b0, 1'b0, "R5");
        step(5, 1'b0, 1'b0, "R5");
        // R3: step left, then busy window
        step(3, 1'b1, 1'b1, "R3");
        step(4, 1'b0, 1'b0, "R9");
        step(4, 1'b1, 1'b1, "R8");
        step(3, 1'b1, 1'b1, "R8");
        step(4, 1'b1, 1'b0, "R8");
        idle(4, SETTLE, "R7");
        step(4, 1'b0, 1'b0, "R3");
        // R10: strip 1 idle while strip 0 worked
        step(6, 1'b1, 1'b1, "R10");
        step(4, 1'b1, 1'b1, "R10");
        idle(7, SETTLE, "R10");
        // R4: back to cell 0, then wrap to the last cell
        step(5, 1'b1, 1'b1, "R4");
        idle(4, SETTLE, "R7");
        step(5, 1'b1, 1'b1, "R4");
        idle(4, SETTLE, "R4");
        step(4, 1'b1, 1'b1, "R4");
        step(3, 1'b1, 1'b1, "R3");
        idle(4, SETTLE, "R3");
        // R3: full lap left returns to start
        for (int i = 0; i < LEN; i++) begin
            step(3, 1'b1, 1'b1, "R3");
            idle(4, SETTLE, "R3");
        end
        // R2: unmapped ports
        step(0, 1'b1, 1'b1, "R2");
        step(1, 1'b1, 1'b1, "R2");
        step(2, 1'b1, 1'b1, "R2");
        step(9, 1'b1, 1'b1, "R2");
        step(4, 1'b0, 1'b0, "R2");
        step(7, 1'b0, 1'b0, "R2");
        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int s = $urandom_range(0, 8);
            bit b = ($urandom_range(0, 3) != 0);
            bit v = 1'($urandom_range(0, 1));
            step(s, b, v, "random:R5,R7,R8");
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule